// File: doc/BRIEF.md
# 8-bit Timer/Counter with Two Compare Channels

This block is a bidirectional 8-bit counter driven by a selectable timer tick, with two output compare channels that watch the count continuously. A 3-bit clock-select field picks no clock, the system clock, one of several prescaled tick inputs, or an edge of an external pin. The external pin passes through a two-flop synchroniser before its edge detector. Four operating modes set how the count wraps and how the two waveform outputs move: free-running, clear at compare A, single-slope PWM and dual-slope (up/down) PWM.

Software reaches the block through a simple write port with five addresses. Address 0 is control, 1 is the count, 2 and 3 are the compare registers of channels A and B, and 4 is the flag register, where writing a 1 clears a flag. In the two PWM modes a compare write is held in a pending register and goes live only at the turnaround point, so the duty cycle never changes in the middle of a period.

Top module: `tmr_core`

## Requirements
- R1: When the clock-select field is 0, the count holds its value whatever the tick inputs do.
- R2: The clock-select field, written to bits [4:2] of address 0, selects the tick source: 0 none, 1 every clock, 2 to 5 `presc_tick[cs-2]`, 6 the falling edge and 7 the rising edge of `ext_pin`. Each external edge, once synchronised through two flops, advances the count by exactly one.
- R3: In mode 0 (bits [1:0] of address 0), the count rises by one on each tick, wraps from 0xFF to 0x00, and sets the overflow flag (`flags_o[0]`) on the tick taken at 0xFF.
- R4: In mode 1, the count wraps to 0x00 on the tick taken when it equals the active compare A value, and that tick sets the overflow flag.
- R5: In mode 3, the count rises to 0xFF, then falls to 0x00, then rises again. The tick taken at 0x00 while falling sets the overflow flag.
- R6: A tick taken while the count equals a channel's active compare value sets that channel's sticky flag (A on `flags_o[1]`, B on `flags_o[2]`). Writing address 4 with a 1 in a bit clears that flag. A set in the same cycle wins over the clear.
- R7: In modes 0 and 1, each channel's waveform output toggles on its compare match.
- R8: In mode 2, the count wraps at 0xFF. Each waveform output is set on the wrap tick and cleared on a match; when both happen on the same tick, the set wins.
- R9: In mode 3, a match while counting up clears the channel's waveform output, and a match while counting down sets it.
- R10: In modes 0 and 1, a compare write takes effect at once. In modes 2 and 3 it is held pending, and the active value loads from it on the tick taken at 0xFF while counting up.
- R11: A write to address 1 loads the count without advancing it that cycle, and suppresses any compare match on the next tick.
- R12: Reset clears the count, the flags, the compare registers, the waveform outputs and control. A write to address 0 clears both waveform outputs and sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 count, 2 compare A, 3 compare B, 4 flags) |
| wr_data | input | 8 | Register write data |
| presc_tick | input | 4 | Prescaled tick pulses, one cycle wide |
| ext_pin | input | 1 | Asynchronous external clock pin |
| count_o | output | 8 | Current count |
| flags_o | output | 3 | Sticky flags: [0] overflow, [1] match A, [2] match B |
| wave_a_o | output | 1 | Channel A waveform output |
| wave_b_o | output | 1 | Channel B waveform output |

## Verification
Each of the four modes is driven from a chosen start count through a chosen number of single prescaled ticks. Start points just below 0xFF and just below a compare value separate a wrap at MAX from a wrap at compare A. A dual-slope run that crosses both turnarounds separates up-count matches from down-count matches. Compare values of 0xFF, and compare writes made in the middle of a PWM period, show whether set-over-clear priority and pending-to-active loading happen on the right tick. Count writes placed on a compare value show the one-tick match suppression, and pulses on unselected prescaler lines and opposite pin edges show that tick selection ignores them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } tmr_mode_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd4;

    localparam int CS_W = 3;
    localparam logic [CS_W-1:0] CS_OFF      = 3'd0;
    localparam logic [CS_W-1:0] CS_CLK      = 3'd1;
    localparam logic [CS_W-1:0] CS_EXT_FALL = 3'd6;
    localparam logic [CS_W-1:0] CS_EXT_RISE = 3'd7;
    localparam int CS_PRESC_BASE = 2;

    localparam int NUM_CHAN = 2;
    localparam int FLAG_OVF = 0;
    localparam int FLAG_CH0 = 1;
endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
    import tmr_pkg::*;
#(
    parameter int NUM_PRESC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CS_W-1:0]      cs,
    input  logic [NUM_PRESC-1:0] presc_tick,
    input  logic                 ext_pin,
    output logic                 tick
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ext_pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;
    assign fall = ~st_q.s2 & st_q.s3;

    always_comb begin
        tick = 1'b0;
        case (cs)
            CS_OFF:      tick = 1'b0;
            CS_CLK:      tick = 1'b1;
            CS_EXT_FALL: tick = fall;
            CS_EXT_RISE: tick = rise;
            default: begin
                for (int i = 0; i < NUM_PRESC; i++) begin
                    if (cs == CS_W'(i + CS_PRESC_BASE)) tick = presc_tick[i];
                end
            end
        endcase
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R2
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] top_cmp,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         restart,
    output logic [W-1:0] count,
    output logic         down,
    output logic         at_top,
    output logic         ovf_evt
);
    localparam logic [W-1:0] MAX = '1;
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_t;

    cnt_t         cs_d, cs_q;
    logic [W-1:0] top;

    always_comb begin
        top     = (mode == MODE_CTC) ? top_cmp : MAX;
        at_top  = (cs_q.cnt == top);
        cs_d    = cs_q;
        ovf_evt = 1'b0;
        if (load_en) begin
            cs_d.cnt = load_val;
        end else if (tick) begin
            if (mode == MODE_PHASE) begin
                if (!cs_q.down) begin
                    if (at_top) begin
                        cs_d.down = 1'b1;
                        cs_d.cnt  = cs_q.cnt - ONE;
                    end else begin
                        cs_d.cnt  = cs_q.cnt + ONE;
                    end
                end else if (cs_q.cnt == '0) begin
                    cs_d.down = 1'b0;
                    cs_d.cnt  = cs_q.cnt + ONE;
                    ovf_evt   = 1'b1;
                end else begin
                    cs_d.cnt = cs_q.cnt - ONE;
                end
            end else if (at_top) begin
                cs_d.cnt = '0;
                ovf_evt  = 1'b1;
            end else begin
                cs_d.cnt = cs_q.cnt + ONE;
            end
        end
        if (restart) cs_d.down = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign count = cs_q.cnt;
    assign down  = cs_q.down;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(count)); // R1
    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && tick && !load_en) |=> count == $past(count) + ONE); // R3
    AST_CTC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTC && tick && !load_en && count == top_cmp) |=> count == '0); // R4
    AST_PHASE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PHASE && tick && !load_en && down && count == '0 && !restart)
        |=> (!down && count == ONE)); // R5
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  tmr_mode_e    mode,
    input  logic         reload,
    input  logic         match_en,
    input  logic [W-1:0] count,
    input  logic         down,
    input  logic         wrap_set,
    input  logic         flag_clr,
    input  logic         restart,
    output logic [W-1:0] active,
    output logic         flag,
    output logic         wave
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
        logic         flag;
        logic         wave;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  pwm;
    logic  match;

    always_comb begin
        pwm   = (mode == MODE_FAST) || (mode == MODE_PHASE);
        match = match_en && (count == ch_q.act);
        ch_d  = ch_q;
        if (wr_en) begin
            ch_d.pend = wr_data;
            if (!pwm) ch_d.act = wr_data;
        end
        if (reload) ch_d.act = ch_q.pend;
        if (match)         ch_d.flag = 1'b1;
        else if (flag_clr) ch_d.flag = 1'b0;
        case (mode)
            MODE_FAST: begin
                if (wrap_set)   ch_d.wave = 1'b1;
                else if (match) ch_d.wave = 1'b0;
            end
            MODE_PHASE: begin
                if (match) ch_d.wave = down;
            end
            default: begin
                if (match) ch_d.wave = ~ch_q.wave;
            end
        endcase
        if (restart) ch_d.wave = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign active = ch_q.act;
    assign flag   = ch_q.flag;
    assign wave   = ch_q.wave;

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(match_en)); // R6
    AST_PWM_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !reload) |=> $stable(active)); // R10
    AST_FAST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAST && wrap_set && !restart) |=> wave); // R8
    AST_PHASE_DOWN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PHASE && match && down && !restart) |=> wave); // R9
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W         = 8,
    parameter int NUM_PRESC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic [NUM_PRESC-1:0] presc_tick,
    input  logic                 ext_pin,
    output logic [W-1:0]         count_o,
    output logic [NUM_CHAN:0]    flags_o,
    output logic                 wave_a_o,
    output logic                 wave_b_o
);
    typedef struct packed {
        tmr_mode_e       mode;
        logic [CS_W-1:0] cs;
        logic            block;
        logic            ovf;
    } ctl_t;

    ctl_t         ct_d, ct_q;
    logic         tick, adv, match_en, reload, wrap_set, pwm;
    logic         ctrl_wr, cnt_wr, flags_wr;
    logic         down, at_top, ovf_evt;
    logic [W-1:0] count;
    logic [W-1:0] cmp_act  [NUM_CHAN];
    logic         cmp_flag [NUM_CHAN];
    logic         cmp_wave [NUM_CHAN];

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign cnt_wr   = wr_en && (wr_addr == ADDR_COUNT);
    assign flags_wr = wr_en && (wr_addr == ADDR_FLAGS);

    tmr_clk_sel #(.NUM_PRESC(NUM_PRESC)) u_clk_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (ct_q.cs),
        .presc_tick (presc_tick),
        .ext_pin    (ext_pin),
        .tick       (tick)
    );

    tmr_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (ct_q.mode),
        .top_cmp  (cmp_act[0]),
        .load_en  (cnt_wr),
        .load_val (wr_data),
        .restart  (ctrl_wr),
        .count    (count),
        .down     (down),
        .at_top   (at_top),
        .ovf_evt  (ovf_evt)
    );

    always_comb begin
        pwm      = (ct_q.mode == MODE_FAST) || (ct_q.mode == MODE_PHASE);
        adv      = tick && !cnt_wr;
        match_en = adv && !ct_q.block;
        reload   = adv && pwm && at_top && !down;
        wrap_set = adv && (ct_q.mode == MODE_FAST) && at_top;
        ct_d     = ct_q;
        if (ctrl_wr) begin
            ct_d.mode = tmr_mode_e'(wr_data[1:0]);
            ct_d.cs   = wr_data[4:2];
        end
        if (cnt_wr)    ct_d.block = 1'b1;
        else if (tick) ct_d.block = 1'b0;
        if (ovf_evt)                            ct_d.ovf = 1'b1;
        else if (flags_wr && wr_data[FLAG_OVF]) ct_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ct_q <= '{mode: MODE_NORMAL, cs: CS_OFF, block: 1'b0, ovf: 1'b0};
        else        ct_q <= ct_d;
    end

    for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
        tmr_cmp_chan #(.W(W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_addr == ADDR_W'(ADDR_CMPA + i))),
            .wr_data  (wr_data),
            .mode     (ct_q.mode),
            .reload   (reload),
            .match_en (match_en),
            .count    (count),
            .down     (down),
            .wrap_set (wrap_set),
            .flag_clr (flags_wr && wr_data[FLAG_CH0 + i]),
            .restart  (ctrl_wr),
            .active   (cmp_act[i]),
            .flag     (cmp_flag[i]),
            .wave     (cmp_wave[i])
        );
        assign flags_o[FLAG_CH0 + i] = cmp_flag[i];
    end

    assign flags_o[FLAG_OVF] = ct_q.ovf;
    assign count_o           = count;
    assign wave_a_o          = cmp_wave[0];
    assign wave_b_o          = cmp_wave[1];

    AST_BLOCK_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.block && tick) |=> !($rose(flags_o[1]) || $rose(flags_o[2]))); // R11
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_wr && wr_data[FLAG_OVF] && !ovf_evt) |=> !flags_o[FLAG_OVF]); // R6
    AST_CTRL_WAVE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (!wave_a_o && !wave_b_o)); // R12
endmodule

// File: tb/tb_tmr_core.sv
module tb_tmr_core;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] presc_tick = '0;
    logic       ext_pin = 1'b0;
    logic [7:0] count_o;
    logic [2:0] flags_o;
    logic       wave_a_o, wave_b_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .presc_tick (presc_tick),
        .ext_pin    (ext_pin),
        .count_o    (count_o),
        .flags_o    (flags_o),
        .wave_a_o   (wave_a_o),
        .wave_b_o   (wave_b_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  start;
        logic [15:0] n;
        logic [7:0]  ecnt;
        logic [2:0]  eflg;
        logic        ewa;
        logic        ewb;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h10, 8'h20, 8'h0E, 16'd4,   8'h12, 3'b010, 1'b1, 1'b0},
        '{2'd0, 8'h01, 8'h80, 8'hFE, 16'd3,   8'h01, 3'b001, 1'b0, 1'b0},
        '{2'd1, 8'h05, 8'h03, 8'h00, 16'd8,   8'h02, 3'b111, 1'b1, 1'b1},
        '{2'd2, 8'h02, 8'h00, 8'hFE, 16'd4,   8'h02, 3'b101, 1'b1, 1'b0},
        '{2'd3, 8'hFD, 8'h02, 8'hFC, 16'd6,   8'hFC, 3'b010, 1'b1, 1'b0},
        '{2'd3, 8'h80, 8'h01, 8'hFF, 16'd256, 8'h01, 3'b111, 1'b1, 1'b1}
    };
    string vreq [NV] = '{"R3 R7", "R3", "R4 R7", "R8 R6", "R9 R5", "R5 R9"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n, input int line);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); presc_tick[line] = 1'b1;
            @(negedge clk); presc_tick[line] = 1'b0;
        end
    endtask

    task automatic setup(input logic [1:0] mode, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] start);
        wr(3'd0, {6'd0, 2'd0});
        wr(3'd2, a);
        wr(3'd3, b);
        wr(3'd0, {3'd0, 3'd2, mode});
        wr(3'd1, start);
        wr(3'd4, 8'h07);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset count", count_o, 0);
        chk("R12 reset flags", flags_o, 0);
        chk("R12 reset waves", {wave_a_o, wave_b_o}, 0);

        // table of mode runs
        for (int v = 0; v < NV; v++) begin
            setup(VEC[v].mode, VEC[v].a, VEC[v].b, VEC[v].start);
            step(int'(VEC[v].n), 0);
            chk({vreq[v], " count"}, count_o, VEC[v].ecnt);
            chk({vreq[v], " flags"}, flags_o, VEC[v].eflg);
            chk({vreq[v], " wave A"}, wave_a_o, VEC[v].ewa);
            chk({vreq[v], " wave B"}, wave_b_o, VEC[v].ewb);
        end

        // R1 no clock source holds count
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h40);
        step(5, 0);
        step(5, 2);
        chk("R1 stopped count", count_o, 8'h40);

        // R2 cs=3 follows presc_tick[1] only
        wr(3'd0, {3'd0, 3'd3, 2'd0});
        step(3, 0);
        chk("R2 unselected prescale line", count_o, 8'h40);
        step(2, 1);
        chk("R2 selected prescale line", count_o, 8'h42);

        // R2 external rising edge
        wr(3'd0, {3'd0, 3'd7, 2'd0});
        @(negedge clk); ext_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 rising edge counts", count_o, 8'h43);
        ext_pin = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 falling edge ignored", count_o, 8'h43);
        // R2 external falling edge
        wr(3'd0, {3'd0, 3'd6, 2'd0});
        ext_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 rising edge ignored", count_o, 8'h43);
        ext_pin = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 falling edge counts", count_o, 8'h44);

        // R2 cs=1 ticks every clock: two clocks pass between the two control writes
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h10);
        wr(3'd0, {3'd0, 3'd1, 2'd0});
        wr(3'd0, 8'h00);
        chk("R2 every-clock source", count_o, 8'h12);

        // R11 count write suppresses the next match
        setup(2'd0, 8'h30, 8'hC0, 8'h30);
        step(1, 0);
        chk("R11 count after blocked tick", count_o, 8'h31);
        chk("R11 no flag on blocked match", flags_o, 3'b000);
        wr(3'd1, 8'h2F);
        step(2, 0);
        chk("R11 match after blocked tick", flags_o, 3'b010);

        // R6 write-one-to-clear per bit
        setup(2'd0, 8'h00, 8'h00, 8'hFF);
        step(2, 0);
        chk("R6 all flags set", flags_o, 3'b111);
        wr(3'd4, 8'h02);
        chk("R6 clear A only", flags_o, 3'b101);
        wr(3'd4, 8'h05);
        chk("R6 clear remaining", flags_o, 3'b000);

        // R10 immediate compare update in mode 0
        setup(2'd0, 8'h00, 8'h40, 8'h20);
        wr(3'd3, 8'h22);
        step(3, 0);
        chk("R10 immediate update count", count_o, 8'h23);
        chk("R10 immediate update match", flags_o, 3'b100);

        // R10 pending compare in fast PWM
        setup(2'd2, 8'h00, 8'h0F, 8'h0A);
        wr(3'd3, 8'h05);
        step(10, 0);
        chk("R10 old value still active", flags_o, 3'b100);
        wr(3'd4, 8'h07);
        step(236, 0);
        chk("R10 wrap count", count_o, 8'h00);
        chk("R8 overflow at wrap", flags_o, 3'b001);
        chk("R8 set at wrap", wave_b_o, 1'b1);
        step(6, 0);
        chk("R10 new value active", flags_o, 3'b111);
        chk("R8 clear on match", wave_b_o, 1'b0);

        // R8 set beats clear when compare is 0xFF
        setup(2'd2, 8'hFF, 8'h10, 8'hFE);
        step(2, 0);
        chk("R8 compare at MAX count", count_o, 8'h00);
        chk("R8 compare at MAX flags", flags_o, 3'b011);
        chk("R8 compare at MAX wave", wave_a_o, 1'b1);

        finish_run();
    end
endmodule